// File: doc/BRIEF.md
# Two-Bit Burst Address Sequencer

This block produces the address for each beat of a four-beat burst into a synchronous memory. A burst begins when either of two active-low start strobes is seen at a rising clock edge. One strobe is meant for a processor and the other for a memory controller. On that edge the block captures the full incoming address. After that, each rising edge that sees the active-low step input asserted moves the burst on by one beat. The upper address bits stay frozen for the whole burst, and only the two low bits change.

An order-select input chooses how the two low bits progress. In linear order they count up modulo four from the captured value. In interleaved order they are the captured low bits XORed with a beat count that runs 0, 1, 2, 3. The block is one register stage: strobes, step and address are taken at the clock edge, and the output follows from the registered state. The order select acts combinationally on that registered state.

Top module: `burst_addr_seq`

## Requirements
- R1: While `rst_n` is low, `addr_out` is all zeros.
- R2: On a rising edge where `start_cpu_n` or `start_ctl_n` (or both) is 0, `addr_in` is captured, and from that edge on `addr_out` equals the captured address with a beat count of 0.
- R3: When a start strobe and `step_n` are both 0 on the same edge, the start wins: `addr_out` becomes `addr_in`, with no step applied.
- R4: With `lin_order` = 1, each edge with `step_n` = 0 and no strobe adds 1 modulo 4 to `addr_out[1:0]`. Starting from low bits 2, the sequence is 2,3,0,1, and the fourth step returns to 2.
- R5: With `lin_order` = 0, `addr_out[1:0]` equals the captured low bits XOR the beat count (0,1,2,3, wrapping). Starting from 1 the sequence is 1,0,3,2. Starting from 2 it is 2,3,0,1.
- R6: On an edge with both strobes at 1 and `step_n` at 1, `addr_out` holds its value.
- R7: Between starts, `addr_out[ADDR_W-1:2]` keeps the captured upper bits, and changes on `addr_in` have no effect on `addr_out`.
- R8: `lin_order` is applied combinationally to the current beat count. With captured low bits 3 and beat 1, `addr_out[1:0]` is 2 in interleaved order and 0 in linear order, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_cpu_n | input | 1 | Processor burst start, active low |
| start_ctl_n | input | 1 | Controller burst start, active low |
| step_n | input | 1 | Advance to the next beat, active low |
| lin_order | input | 1 | 1 = linear order, 0 = interleaved order |
| addr_in | input | ADDR_W | Incoming full address |
| addr_out | output | ADDR_W | Current beat address |

## Verification
Start, step and hold each take effect at the first rising edge that samples them. The new `addr_out` is therefore due in that same cycle, and the bench samples it 5 ns after that edge. Inputs are driven at that same point, away from any edge. An order change has no register in its path, so the bench checks it 1 ns after driving `lin_order`, with no clock edge in between. The expected addresses are worked out inside each scenario task from the start value and the number of steps.

// File: rtl/burst_addr_seq.sv
module burst_addr_seq #(
  parameter int ADDR_W = 17
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_cpu_n,
  input  logic              start_ctl_n,
  input  logic              step_n,
  input  logic              lin_order,
  input  logic [ADDR_W-1:0] addr_in,
  output logic [ADDR_W-1:0] addr_out
);
  localparam int BEAT_W = 2;
  localparam int UP_W   = ADDR_W - BEAT_W;

  logic [ADDR_W-1:0] base_q;
  logic [BEAT_W-1:0] beat_q;
  logic [BEAT_W-1:0] low;
  logic              start;

  assign start = !start_cpu_n || !start_ctl_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      beat_q <= '0;
    end else if (start) begin
      base_q <= addr_in;
      beat_q <= '0;
    end else if (!step_n) begin
      beat_q <= beat_q + 1'b1;
    end
  end

  assign low      = lin_order ? base_q[BEAT_W-1:0] + beat_q
                              : base_q[BEAT_W-1:0] ^ beat_q;
  assign addr_out = {base_q[ADDR_W-1:BEAT_W], low};

  // R1
  always_comb if (!rst_n) reset_zero_chk: assert (addr_out == '0);

  // R2 R3
  start_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> addr_out == $past(addr_in));

  // R4
  lin_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && !step_n && lin_order) |=>
      (!lin_order || addr_out[BEAT_W-1:0] == $past(addr_out[BEAT_W-1:0]) + 2'd1));

  // R6
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && step_n) |=> ($stable(base_q) && $stable(beat_q)));

  // R7
  upper_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> addr_out[ADDR_W-1:BEAT_W] == $past(addr_out[ADDR_W-1:BEAT_W]));

  // R5
  ilv_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && !step_n && !lin_order) |=>
      (lin_order || $countones(addr_out[BEAT_W-1:0] ^ $past(addr_out[BEAT_W-1:0])) != 0));

  logic [UP_W-1:0] unused_up;
  assign unused_up = base_q[ADDR_W-1:BEAT_W];
endmodule

// File: tb/tb_burst_addr_seq.sv
`timescale 1ns/1ps
module tb_burst_addr_seq;
  localparam int AW = 17;
  logic clk = 0, rst_n = 0;
  logic start_cpu_n = 1, start_ctl_n = 1, step_n = 1, lin_order = 1;
  logic [AW-1:0] addr_in = '0;
  logic [AW-1:0] addr_out;
  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  burst_addr_seq #(.ADDR_W(AW)) dut (
    .clk(clk), .rst_n(rst_n), .start_cpu_n(start_cpu_n), .start_ctl_n(start_ctl_n),
    .step_n(step_n), .lin_order(lin_order), .addr_in(addr_in), .addr_out(addr_out));

  task automatic check(input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #5;
  endtask

  task automatic load(input logic use_cpu, input logic [AW-1:0] a);
    addr_in = a; start_cpu_n = !use_cpu; start_ctl_n = use_cpu; step_n = 1;
    tick();
    start_cpu_n = 1; start_ctl_n = 1;
  endtask

  task automatic t_reset();
    rst_n = 0; addr_in = 17'h1FFFF; start_cpu_n = 0;
    #3 check("R1 reset", addr_out, '0);
    tick(); check("R1 reset held", addr_out, '0);
    start_cpu_n = 1; rst_n = 1; tick();
  endtask

  task automatic t_start();
    load(1, 17'h1ABCD); check("R2 cpu start", addr_out, 17'h1ABCD);
    load(0, 17'h05432); check("R2 ctl start", addr_out, 17'h05432);
  endtask

  task automatic t_linear();
    logic [AW-1:0] s = 17'h0AAA6;
    lin_order = 1; load(1, s);
    for (int i = 1; i <= 4; i++) begin
      addr_in = 17'h1FFFF - AW'(i); step_n = 0; tick();
      check("R4 linear step / R7 upper", addr_out, {s[AW-1:2], 2'(s[1:0] + 2'(i))});
    end
    step_n = 1;
  endtask

  task automatic t_interleave(input logic [1:0] lo);
    logic [AW-1:0] s = {15'h3C3C, lo};
    lin_order = 0; load(0, s);
    for (int i = 1; i <= 4; i++) begin
      step_n = 0; addr_in = 17'h00000; tick();
      check("R5 interleaved step / R7 upper", addr_out, {s[AW-1:2], 2'(lo ^ 2'(i))});
    end
    step_n = 1;
  endtask

  task automatic t_hold();
    logic [AW-1:0] v;
    lin_order = 1; load(1, 17'h12341); step_n = 0; tick(); step_n = 1;
    v = addr_out;
    for (int i = 0; i < 3; i++) begin
      addr_in = 17'h0F0F0 + AW'(i); tick();
      check("R6 hold / R7 addr_in ignored", addr_out, v);
    end
  endtask

  task automatic t_priority();
    lin_order = 1; load(1, 17'h00100); step_n = 0; tick();
    addr_in = 17'h1C001; start_ctl_n = 0; step_n = 0; tick();
    check("R3 start beats step", addr_out, 17'h1C001);
    start_ctl_n = 1; addr_in = 17'h0B002; start_cpu_n = 0; tick();
    check("R3 cpu start beats step", addr_out, 17'h0B002);
    start_cpu_n = 1; step_n = 1;
  endtask

  task automatic t_mode_switch();
    lin_order = 0; load(1, 17'h08883); step_n = 0; tick(); step_n = 1;
    check("R8 interleaved beat1", addr_out, 17'h08882);
    lin_order = 1; #1;
    check("R8 linear beat1 no edge", addr_out, 17'h08880);
    lin_order = 0; #1;
    check("R8 back to interleaved", addr_out, 17'h08882);
  endtask

  initial begin
    fork
      begin
        t_reset(); t_start(); t_linear(); t_interleave(2'd1); t_interleave(2'd2);
        t_hold(); t_priority(); t_mode_switch();
      end
      begin
        repeat (5000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule